// File: doc/BRIEF.md
# Synchronous Burst Read Interface

This block is the host-facing read port of a 16-bit word memory. It leaves reset in an asynchronous page-read mode: while the enable input is high, every clock returns the word at the address presented on that clock. A write to a small read-configuration register moves the port into clocked burst mode. In that mode, a load strobe captures a start address, and a programmable initial latency then passes with no data. After that, an internal counter walks through consecutive addresses and sends one word out on every clock, or one word on every second clock.

A ready flag with selectable polarity tells the host in which cycles the data bus carries a valid word. Dropping the enable input ends a burst at once, and the port stops driving its outputs. The counter is a single linear address, so a burst crosses partition boundaries and wraps at the top of the address space without a pause. The array behind the port is a synchronous read-only store with a computed pattern.

Data leaves the block with a fixed, known latency. There is no back-pressure. The host must take each word in the cycles where the ready flag marks it valid, and a word presented with the two-clock hold is valid for both of its cycles. To pause a burst, the host drops the enable input and then reloads the address.

Top module: `sburst_rd`

## Requirements
- R1: After reset, the configuration is asynchronous mode with latency field 7, single-clock hold and active-high ready (value 0x2E). `rd_oe` is 0, `rd_data` is 0 and `rdy_flag` is 0.
- R2: In asynchronous mode, when `bus_en` is high at a rising edge, after that edge `rd_oe` is 1, the ready flag shows valid, and `rd_data` is M(a) for the `addr_in` sampled at that edge. M(a) is the low 16 bits of (a × 0x9E37), XORed with 0x5A5A. `addr_ld` has no effect in this mode.
- R3: A `cfg_wr` pulse stores `cfg_din`, which takes effect from the next edge. The fields are: bit 0 selects burst mode (1) or asynchronous mode (0); bits 3:1 hold the latency L; bit 4 selects the two-clock hold; bit 5 gives the ready polarity.
- R4: In burst mode, `bus_en` and `addr_ld` high at edge k load start address A. `rd_oe` is 1 and the ready flag shows not-valid after edges k through k+L-1. The first word M(A) appears after edge k+L.
- R5: A latency field of 0 or 1 acts as a latency of 2.
- R6: With single-clock hold, word i of the burst, M(A+i), appears after edge k+L+i.
- R7: With two-clock hold, word i appears after edges k+L+2i and k+L+2i+1.
- R8: When bit 5 is 1, `rdy_flag` is 1 exactly when data is valid. When bit 5 is 0, it is 0 exactly when data is valid. This includes the cycles where nothing is driven.
- R9: The burst address steps by one through every boundary. 0x0FFF is followed by 0x1000, and 0xFFFF is followed by 0x0000.
- R10: A configuration write that arrives while a burst is loaded, waiting or streaming is dropped.
- R11: After an edge where `bus_en` is low, `rd_oe` is 0, `rd_data` is 0 and the flag shows not-valid. In burst mode, raising `bus_en` again without `addr_ld` drives nothing.
- R12: An `addr_ld` during a running burst restarts it from the new address with a full latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_din | input | 6 | Configuration value |
| bus_en | input | 1 | Port enable; low ends any access |
| addr_ld | input | 1 | Start-address load strobe (burst mode) |
| addr_in | input | AW | Word address |
| rd_data | output | 16 | Read data, 0 when not valid |
| rd_oe | output | 1 | Output-drive enable (0 means high impedance at the pads) |
| rdy_flag | output | 1 | Data-valid indication, polarity from configuration |

## Verification
The bench attacks the edges of the latency window: both clamped latency codes and the longest latency. An off-by-one counter there shifts every word one clock early or late. Under two-clock hold, a design that advanced the address each clock would skip words, and the bench catches that. Bursts started just below 0x1000 and 0xFFFF show whether the counter carries cleanly or stalls. A configuration write inside a burst, an enable drop in mid-stream and a reload in mid-burst all test state that a careless design would keep or lose wrongly. In each of these cases the design would present the wrong latency or leave the outputs driven.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int DW      = 16;
  localparam int CFG_W   = 6;
  localparam int LAT_W   = 3;
  localparam int LAT_MIN = 2;

  typedef struct packed {
    logic             rdy_hi;   // bit 5
    logic             hold2;    // bit 4
    logic [LAT_W-1:0] lat;      // bits 3:1
    logic             sync_en;  // bit 0
  } rcfg_t;

  localparam rcfg_t RCFG_RST = '{rdy_hi: 1'b1, hold2: 1'b0, lat: 3'd7, sync_en: 1'b0};

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_STREAM} bst_t;

  function automatic logic [DW-1:0] cell_word(input logic [31:0] a);
    return DW'(a * 32'h0000_9E37) ^ DW'(32'h0000_5A5A);
  endfunction

  function automatic logic [LAT_W-1:0] eff_lat(input logic [LAT_W-1:0] f);
    return (f < LAT_W'(LAT_MIN)) ? LAT_W'(LAT_MIN) : f;
  endfunction
endpackage

// File: rtl/sbr_cfg.sv
module sbr_cfg
  import sbr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CFG_W-1:0] wr_data,
  input  logic             lock,
  output rcfg_t            cfg
);
  // Writes are dropped while a burst owns the port.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cfg <= RCFG_RST;
    else if (wr_en && !lock) cfg <= rcfg_t'(wr_data);
  end
endmodule

// File: rtl/sbr_array.sv
module sbr_array
  import sbr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] q
);
  // Registered read; q holds its word when no read is issued.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (rd_en) q <= cell_word(32'(rd_addr));
  end
endmodule

// File: rtl/sbr_seq.sv
module sbr_seq
  import sbr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             addr_ld,
  input  logic [AW-1:0]    addr_in,
  input  logic             sync_en,
  input  logic             hold2,
  input  logic [LAT_W-1:0] lat,
  output logic             busy,
  output logic             step,
  output logic [AW-1:0]    ptr,
  output logic             vld,
  output logic             oe
);
  bst_t             st;
  logic [LAT_W-1:0] wcnt;
  logic             ph;

  assign busy = (st != S_IDLE);

  // step: read the word at ptr on this edge and advance the counter
  always_comb begin
    step = 1'b0;
    if (bus_en && sync_en && !addr_ld) begin
      unique case (st)
        S_WAIT:   step = (wcnt == '0);
        S_STREAM: step = !(hold2 && ph);
        default:  step = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      wcnt <= '0;
      ptr  <= '0;
      ph   <= 1'b0;
      vld  <= 1'b0;
      oe   <= 1'b0;
    end else if (!bus_en) begin
      st  <= S_IDLE;
      ph  <= 1'b0;
      vld <= 1'b0;
      oe  <= 1'b0;
    end else if (!sync_en) begin
      st  <= S_IDLE;
      ph  <= 1'b0;
      vld <= 1'b1;
      oe  <= 1'b1;
    end else if (addr_ld) begin
      st   <= S_WAIT;
      ptr  <= addr_in;
      wcnt <= eff_lat(lat) - LAT_W'(1);
      ph   <= 1'b0;
      vld  <= 1'b0;
      oe   <= 1'b1;
    end else begin
      if (step) ptr <= ptr + 1'b1;
      unique case (st)
        S_WAIT: begin
          if (step) begin
            st  <= S_STREAM;
            vld <= 1'b1;
            ph  <= hold2;
          end else begin
            wcnt <= wcnt - LAT_W'(1);
          end
        end
        S_STREAM: ph <= step ? hold2 : 1'b0;
        default: begin
          vld <= 1'b0;
          oe  <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/sburst_rd.sv
module sburst_rd
  import sbr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_din,
  input  logic             bus_en,
  input  logic             addr_ld,
  input  logic [AW-1:0]    addr_in,
  output logic [DW-1:0]    rd_data,
  output logic             rd_oe,
  output logic             rdy_flag
);
  rcfg_t         cfg;
  logic          busy;
  logic          step;
  logic          data_vld;
  logic          drv;
  logic [AW-1:0] ptr;
  logic          rom_en;
  logic [AW-1:0] rom_addr;
  logic [DW-1:0] rom_q;

  sbr_cfg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (cfg_din),
    .lock    (busy),
    .cfg     (cfg)
  );

  sbr_seq #(.AW(AW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_en  (bus_en),
    .addr_ld (addr_ld),
    .addr_in (addr_in),
    .sync_en (cfg.sync_en),
    .hold2   (cfg.hold2),
    .lat     (cfg.lat),
    .busy    (busy),
    .step    (step),
    .ptr     (ptr),
    .vld     (data_vld),
    .oe      (drv)
  );

  // Asynchronous mode reads the pins directly; burst mode reads the counter.
  assign rom_en   = step | (bus_en & ~cfg.sync_en);
  assign rom_addr = cfg.sync_en ? ptr : addr_in;

  sbr_array #(.AW(AW)) u_arr (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rom_en),
    .rd_addr (rom_addr),
    .q       (rom_q)
  );

  assign rd_data  = data_vld ? rom_q : '0;
  assign rd_oe    = drv;
  assign rdy_flag = cfg.rdy_hi ? data_vld : ~data_vld;
endmodule

// File: rtl/sbr_chk.sv
module sbr_chk
  import sbr_pkg::*;
#(
  parameter int AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_en,
  input logic             addr_ld,
  input logic             cfg_wr,
  input logic [AW-1:0]    addr_in,
  input logic [DW-1:0]    rd_data,
  input logic             rd_oe,
  input logic             rdy_flag,
  input logic [CFG_W-1:0] cfg_bits,
  input logic             busy,
  input logic             step,
  input logic [AW-1:0]    ptr,
  input logic             data_vld
);
  a_r11_release: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> (!rd_oe && rd_data == '0 && rdy_flag == !cfg_bits[5]));

  a_r2_async_word: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !cfg_bits[0]) |=> (rd_oe && rd_data == cell_word(32'($past(addr_in)))));

  a_r10_cfg_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cfg_wr) |=> $stable(cfg_bits));

  a_r4_no_early_data: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && addr_ld && cfg_bits[0]) |=> (rd_oe && !data_vld));

  a_r9_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ptr == $past(ptr) + 1'b1));

  a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_oe |-> (rdy_flag == !cfg_bits[5]));
endmodule

bind sburst_rd sbr_chk #(.AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_en   (bus_en),
  .addr_ld  (addr_ld),
  .cfg_wr   (cfg_wr),
  .addr_in  (addr_in),
  .rd_data  (rd_data),
  .rd_oe    (rd_oe),
  .rdy_flag (rdy_flag),
  .cfg_bits (cfg),
  .busy     (busy),
  .step     (step),
  .ptr      (ptr),
  .data_vld (data_vld)
);

// File: tb/sburst_rd_tb.sv
module sburst_rd_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 16;
  localparam int WD    = 100000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [5:0]    cfg_din = '0;
  logic          bus_en = 1'b0;
  logic          addr_ld = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [15:0]   rd_data;
  logic          rd_oe;
  logic          rdy_flag;

  int    n_chk = 0;
  int    n_err = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  always #(CLK_P/2) clk = ~clk;

  sburst_rd #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_din(cfg_din),
    .bus_en(bus_en), .addr_ld(addr_ld), .addr_in(addr_in),
    .rd_data(rd_data), .rd_oe(rd_oe), .rdy_flag(rdy_flag)
  );

  function automatic logic [15:0] ref_word(input int unsigned a);
    int unsigned p;
    p = a * 32'h9E37;
    return p[15:0] ^ 16'h5A5A;
  endfunction

  // Behavioural reference: cycles since load decide which word is due.
  logic [5:0]  m_cfg = 6'h2E;
  bit          m_busy = 0;
  bit          m_vld = 0;
  bit          m_oe = 0;
  logic [15:0] m_data = '0;
  int          m_n = 0;
  int          m_lat = 2;
  int unsigned m_start = 0;
  logic [5:0]  oc;
  bit          ob;
  int          idx;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = 6'h2E; m_busy = 0; m_vld = 0; m_oe = 0; m_data = '0;
    end else begin
      oc = m_cfg;
      ob = m_busy;
      if (cfg_wr && !ob) m_cfg = cfg_din;
      if (!bus_en) begin
        m_busy = 0; m_oe = 0; m_vld = 0;
      end else if (!oc[0]) begin
        m_busy = 0; m_oe = 1; m_vld = 1; m_data = ref_word(32'(addr_in));
      end else if (addr_ld) begin
        m_busy = 1; m_n = 0; m_start = 32'(addr_in); m_oe = 1; m_vld = 0;
        m_lat = (int'(oc[3:1]) < 2) ? 2 : int'(oc[3:1]);
      end else if (m_busy) begin
        m_n++;
        if (m_n >= m_lat) begin
          idx = oc[4] ? (m_n - m_lat) / 2 : (m_n - m_lat);
          m_vld = 1;
          m_data = ref_word((m_start + 32'(idx)) & 32'hFFFF);
        end
      end else begin
        m_oe = 0; m_vld = 0;
      end
    end
  end

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check(cur_req, "rd_oe", 32'(rd_oe), 32'(m_oe));
      check(cur_req, "rd_data", 32'(rd_data), m_vld ? 32'(m_data) : 32'd0);
      check(cur_req, "rdy_flag", 32'(rdy_flag), 32'(m_cfg[5] ? m_vld : !m_vld));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD && !done) begin
      done = 1;
      n_err++;
      $display("FAIL %s watchdog: actual %0d cycles expected below %0d", cur_req, cyc, WD);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  task automatic wcfg(input logic [5:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_din = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    @(negedge clk); bus_en = 1'b0; addr_ld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic burst(input logic [AW-1:0] a, input int n);
    @(negedge clk); bus_en = 1'b1; addr_ld = 1'b1; addr_in = a;
    @(negedge clk); addr_ld = 1'b0; addr_in = a ^ 16'h3C3C; // pins ignored mid-burst
    repeat (n) @(negedge clk);
  endtask

  initial begin
    // R1: reset values observed at the ports
    cur_req = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: asynchronous reads, load strobe has no effect
    cur_req = "R2";
    @(negedge clk); bus_en = 1'b1; addr_in = 16'h0000;
    @(negedge clk); addr_in = 16'h0001; addr_ld = 1'b1;
    @(negedge clk); addr_in = 16'h1234; addr_ld = 1'b0;
    @(negedge clk); addr_in = 16'hFFFF; addr_ld = 1'b1;
    @(negedge clk); addr_ld = 1'b0;
    idle(2);

    // R3/R4/R6: burst, latency 3, single hold, active-high ready
    cur_req = "R3";
    wcfg(6'h27);
    cur_req = "R4";
    burst(16'h0100, 3);
    cur_req = "R6";
    repeat (8) @(negedge clk);
    idle(2);

    // R4: longest latency
    cur_req = "R4";
    wcfg(6'h2F);
    burst(16'h0200, 12);
    idle(2);

    // R5: latency codes 0 and 1 behave as 2
    cur_req = "R5";
    wcfg(6'h21);
    burst(16'h0300, 6);
    idle(1);
    wcfg(6'h23);
    burst(16'h0310, 6);
    idle(2);

    // R7: two-clock hold, latency 4
    cur_req = "R7";
    wcfg(6'h39);
    burst(16'h0400, 14);
    idle(2);

    // R8: inverted ready polarity, also while idle
    cur_req = "R8";
    wcfg(6'h19);
    idle(2);
    burst(16'h0500, 10);
    idle(3);

    // R9: partition boundary and address wrap
    cur_req = "R9";
    wcfg(6'h25);
    burst(16'h0FFC, 10);
    idle(1);
    burst(16'hFFFD, 8);
    idle(2);

    // R10: configuration write during a burst is dropped
    cur_req = "R10";
    wcfg(6'h27);
    burst(16'h0600, 1);
    @(negedge clk); cfg_wr = 1'b1; cfg_din = 6'h1E;
    @(negedge clk); cfg_wr = 1'b0;
    repeat (5) @(negedge clk);
    idle(1);
    burst(16'h0610, 6);
    idle(2);

    // R11: enable drop mid-burst, then enable without load
    cur_req = "R11";
    burst(16'h0700, 6);
    idle(2);
    @(negedge clk); bus_en = 1'b1;
    repeat (4) @(negedge clk);
    idle(2);

    // R12: reload during a running burst
    cur_req = "R12";
    burst(16'h0800, 5);
    @(negedge clk); addr_ld = 1'b1; addr_in = 16'h0A00;
    @(negedge clk); addr_ld = 1'b0;
    repeat (7) @(negedge clk);
    idle(2);

    // R3: back to asynchronous mode
    cur_req = "R3";
    wcfg(6'h2E);
    @(negedge clk); bus_en = 1'b1; addr_in = 16'h4321;
    @(negedge clk); addr_in = 16'h4322;
    @(negedge clk);
    idle(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule